// File: doc/BRIEF.md
# Free-Running Microsecond Timer with Compare Channels

The block keeps a free-running up-counter that advances once per microsecond tick. The tick is made by dividing the system clock by a parameter. The counter is split into a low word of `LO_W` bits, which is 32 by default, and a 32-bit high word. Four compare registers are each matched against the low word only. When the low word steps onto a channel's compare value, that channel's flag in the shared status word is set. The flag drives that channel's interrupt line as a plain level, with no mask.

Software reaches the block through a small synchronous register port. Writes take effect at the clock edge. Reads are combinational from the address. Software reads the low and high counter words as two separate accesses, and must read the high word again until two reads agree, because the high word can change between them. A flag is cleared by writing a one to its bit in the status word. Writing the compare register does not clear a flag.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset, every register reads zero and all four interrupt outputs are low.
- R2: The counter advances by exactly one every `DIV` clock cycles and holds its value in between. Word offset 1 returns the low `LO_W` bits of the counter, zero-extended to 32 bits.
- R3: Word offset 2 returns the upper 32 bits of the counter. This word increments on the tick where the low word wraps from all ones to zero.
- R4: Word offsets 3, 4, 5 and 6 hold the compare values for channels 0 to 3. Each keeps the low `LO_W` bits of the written data and reads them back zero-extended.
- R5: Status bit n, at word offset 0 bit n, is set on the tick where the low counter word becomes equal to compare n. A compare write in that same cycle does not affect this match, which uses the value held before the write.
- R6: A write to offset 0 clears each status bit whose data bit (bits 3 to 0) is one. Status bits whose data bit is zero are left unchanged.
- R7: If a clear and a new match for the same channel fall in the same cycle, the flag ends up set.
- R8: A set flag stays set until it is cleared through offset 0. This holds even if its compare register is rewritten.
- R9: Output `irq[n]` always equals status bit n.
- R10: Writes to offsets 1 and 2 are ignored. Offset 7 reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 4 | Per-channel interrupt level |

## Verification
A software clear of a status bit and a new match on the same channel can fall in the same clock cycle. The bench provokes this by loading compare 0 just ahead of the counter. It then watches its own model of the divider and counter, and issues a write-one-to-clear of bit 0 on exactly the cycle before the matching tick edge. The flag must read as set afterwards, and the interrupt line must follow it. Throughout the run, a cycle-by-cycle model of the counter and flags is compared with every interrupt output.

// File: rtl/tick_cmp_timer.sv
`timescale 1ns/1ps
module tick_cmp_timer #(
  parameter int DIV  = 100,
  parameter int LO_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [3:0]  irq
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int CW = LO_W + 32;

  logic [DW-1:0]   div_cnt;
  logic            tick;
  logic [CW-1:0]   cnt;
  logic [LO_W-1:0] lo_next;
  logic [LO_W-1:0] cmp [4];
  logic [3:0]      stat, set_vec, clr_vec;

  assign tick    = (div_cnt == DW'(DIV - 1));
  assign lo_next = cnt[LO_W-1:0] + LO_W'(1);
  assign clr_vec = (bus_wr && bus_addr == 3'd0) ? bus_wdata[3:0] : 4'b0;
  assign irq     = stat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      cnt     <= '0;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + DW'(1);
      if (tick) cnt <= cnt + CW'(1);
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_ch
    assign set_vec[g] = tick && (lo_next == cmp[g]);
    always_ff @(posedge clk) begin
      if (!rst_n)                                 cmp[g] <= '0;
      else if (bus_wr && bus_addr == 3'(3 + g))   cmp[g] <= bus_wdata[LO_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~clr_vec) | set_vec;
  end

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = {28'b0, stat};
      3'd1:    bus_rdata = 32'(cnt[LO_W-1:0]);
      3'd2:    bus_rdata = cnt[CW-1:LO_W];
      3'd3:    bus_rdata = 32'(cmp[0]);
      3'd4:    bus_rdata = 32'(cmp[1]);
      3'd5:    bus_rdata = 32'(cmp[2]);
      3'd6:    bus_rdata = 32'(cmp[3]);
      default: bus_rdata = 32'b0;
    endcase
  end
endmodule

// File: rtl/tick_cmp_timer_chk.sv
`timescale 1ns/1ps
module tick_cmp_timer_chk #(
  parameter int DIV  = 100,
  parameter int LO_W = 32,
  parameter int DW   = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic [DW-1:0]      div_cnt,
  input logic [LO_W+31:0]   cnt,
  input logic [3:0]         set_vec,
  input logic               bus_wr,
  input logic [2:0]         bus_addr,
  input logic [3:0]         wclr,
  input logic [3:0]         irq
);
  localparam int CW = LO_W + 32;

  assert_div_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt <= DW'(DIV - 1));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == $past(cnt) + CW'(1));

  assert_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (&cnt[LO_W-1:0])) |=> cnt[CW-1:LO_W] == $past(cnt[CW-1:LO_W]) + 32'd1);

  assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd0) |=> (irq & $past(wclr) & ~$past(set_vec)) == 4'b0);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> (irq & $past(set_vec)) == $past(set_vec));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 3'd0) |=> (irq & $past(irq)) == $past(irq));
endmodule

bind tick_cmp_timer tick_cmp_timer_chk #(.DIV(DIV), .LO_W(LO_W), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .div_cnt(div_cnt), .cnt(cnt),
  .set_vec(set_vec), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wclr(bus_wdata[3:0]), .irq(irq));

// File: tb/tick_cmp_timer_tb_top.sv
`timescale 1ns/1ps
module tick_cmp_timer_tb_top;
  localparam int DIV  = 3;
  localparam int LO_W = 8;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [2:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq;

  int checks = 0, fails = 0;
  bit done = 0;

  tick_cmp_timer #(.DIV(DIV), .LO_W(LO_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #2 clk = ~clk;

  // reference model, updated from the requirements at each rising edge
  int              mdiv;
  logic [39:0]     mcnt;
  logic [7:0]      mcmp [4];
  logic [3:0]      mstat;

  always @(posedge clk) begin
    if (!rst_n) begin
      mdiv = 0; mcnt = '0; mstat = '0;
      for (int i = 0; i < 4; i++) mcmp[i] = '0;
    end else begin
      logic [3:0] s, c;
      logic [7:0] nlo;
      s = '0;
      nlo = mcnt[7:0] + 8'd1;
      if (mdiv == DIV - 1) begin
        for (int i = 0; i < 4; i++) if (mcmp[i] == nlo) s[i] = 1'b1;
        mcnt = mcnt + 40'd1;
        mdiv = 0;
      end else mdiv = mdiv + 1;
      c = (bus_wr && bus_addr == 3'd0) ? bus_wdata[3:0] : 4'b0;
      mstat = (mstat & ~c) | s;
      if (bus_wr && bus_addr >= 3'd3 && bus_addr <= 3'd6)
        mcmp[bus_addr - 3'd3] = bus_wdata[7:0];
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R9: interrupt lines track the flag model every cycle
  always @(negedge clk) if (rst_n && !done)
    check(irq == mstat, "R9 irq level", {28'b0, irq}, {28'b0, mstat});

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_wdata = 0;
  endtask

  function automatic logic [31:0] mread(input logic [2:0] a);
    case (a)
      3'd0: return {28'b0, mstat};
      3'd1: return {24'b0, mcnt[7:0]};
      3'd2: return mcnt[39:8];
      3'd3, 3'd4, 3'd5, 3'd6: return {24'b0, mcmp[a - 3'd3]};
      default: return 32'b0;
    endcase
  endfunction

  task automatic rd_chk(input logic [2:0] a, input string req);
    logic [31:0] e;
    bus_addr = a;
    #0.5;
    e = mread(a);
    check(bus_rdata == e, req, bus_rdata, e);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      bus_addr = 3'(a); #0.5;
      check(bus_rdata == 0, "R1 reset register", bus_rdata, 0);
    end
    check(irq == 0, "R1 reset irq", {28'b0, irq}, 0);

    // R4: compare read-back, only low bits kept
    wr(3, 32'hABCD_0012); wr(4, 32'h0000_0115); wr(5, 32'h1F); wr(6, 32'hC8);
    for (int a = 3; a < 7; a++) rd_chk(3'(a), "R4 compare readback");

    // R2: counter steps every DIV cycles
    @(negedge clk);
    for (int n = 0; n < 30; n++) begin
      rd_chk(1, "R2 low word");
      @(negedge clk);
    end

    // R5: flag sets exactly when the low word reaches compare 1
    wr(0, 32'hF);
    wr(4, {24'b0, mcnt[7:0] + 8'd4});
    rd_chk(0, "R5 flag clear before match");
    repeat (6 * DIV) @(negedge clk);
    check(irq[1] == 1'b1, "R5 channel 1 matched", {31'b0, irq[1]}, 1);

    // R8: rewriting compare keeps flag
    wr(4, 32'h77);
    check(irq[1] == 1'b1, "R8 flag sticky after compare write", {31'b0, irq[1]}, 1);
    repeat (5) @(negedge clk);
    check(irq[1] == 1'b1, "R8 flag sticky later", {31'b0, irq[1]}, 1);

    // R6: write-one-to-clear only touches bits written one
    wr(3, {24'b0, mcnt[7:0] + 8'd3});
    wr(5, {24'b0, mcnt[7:0] + 8'd3});
    repeat (5 * DIV) @(negedge clk);
    rd_chk(0, "R6 before clear");
    wr(0, 32'h2);
    rd_chk(0, "R6 clear bit1 only");
    check(irq[0] == 1'b1 && irq[2] == 1'b1, "R6 untouched bits", {28'b0, irq}, 4'b0101);
    wr(0, 32'h5);
    rd_chk(0, "R6 clear remaining");

    // R10: counter words ignore writes, offset 7 reads zero
    wr(1, 32'hFFFF_FFFF);
    rd_chk(1, "R10 low word ignores write");
    wr(2, 32'h1234_5678);
    rd_chk(2, "R10 high word ignores write");
    wr(7, 32'hFFFF_FFFF);
    rd_chk(7, "R10 offset 7 zero");

    // R7: clear and match on the same edge
    wr(3, {24'b0, mcnt[7:0] + 8'd4});
    forever begin
      @(negedge clk);
      if (mdiv == DIV - 1 && (mcnt[7:0] + 8'd1) == mcmp[0]) break;
    end
    bus_wr = 1; bus_addr = 0; bus_wdata = 32'h1;
    @(negedge clk);
    bus_wr = 0; bus_wdata = 0;
    check(irq[0] == 1'b1, "R7 set wins over clear", {31'b0, irq[0]}, 1);
    rd_chk(0, "R7 status word");

    // sweep of compare values across several low-word wraps (R2, R3, R5)
    for (int r = 0; r < 16; r++) begin
      for (int ch = 0; ch < 4; ch++)
        wr(3'(3 + ch), 32'((r * 16 + ch * 5 + 3) & 255));
      wr(0, 32'hF);
      repeat (130) @(negedge clk);
      rd_chk(0, "R5 sweep status");
      rd_chk(1, "R2 sweep low word");
      rd_chk(2, "R3 sweep high word");
    end
    check(mcnt[39:8] != 0, "R3 high word advanced", mcnt[39:8], 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule